// File: doc/BRIEF.md
# Write-Only I2C Control Target

This block is a receive-only I2C target that lives entirely in the system clock domain. It samples the bus clock and data lines through synchronizer flops. From the synchronized samples it detects START and STOP conditions and rising and falling clock edges. It then collects an address byte, most significant bit first. If the byte names this target with the write direction, the target acknowledges it by pulling the data line low. After that it receives a stream of data bytes, acknowledges each one and hands each byte to a downstream register decoder.

The target address is fixed except for one bit, which an external select pin supplies. Two such targets can therefore share one bus. Each received byte leaves the block as a one-cycle strobe with the byte beside it. The strobe comes before the acknowledge pulse for that byte. The block has no read path, it never stretches the clock, and it does not support extended addressing or general call. The data line leaves the block only as an open-drain pull-low enable.

Top module: `i2c_wr_sink`

## Requirements
- R1: While reset is high and right after reset, the pull-low enable is 0, the strobe is 0 and the byte output is 0x00.
- R2: The target acknowledges an address byte equal to binary 1111_10S0, where S is the level of `addr_sel_i` and bit 0 (the direction bit) is 0. It acknowledges by driving the pull-low enable to 1 for the whole ninth clock pulse.
- R3: The target does not acknowledge any other address byte, including 1111_10S1 (a read) and bytes built with the wrong select value. It then produces no strobe and no acknowledge until the next START or STOP.
- R4: After a matching address, each data byte is assembled from the data levels at eight SCL rising edges, MSB first. The target presents the byte with a strobe that lasts exactly one system clock, and the strobe falls before the pull-low enable rises for that byte's acknowledge.
- R5: Every data byte after a matching address is acknowledged, and any number of bytes may follow one another until a STOP.
- R6: A repeated START at any point restarts address reception. A partly received byte is discarded without a strobe.
- R7: A STOP returns the target to idle. Clock pulses that follow without a new START produce neither a strobe nor an acknowledge.
- R8: The pull-low enable changes only while the synchronized SCL is low.
- R9: The strobe rises on the third system clock edge after the SCL pin rises for the eighth data bit. That is one edge per synchronizer stage (two by default) plus one for the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Supplies address bit 1 |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| byte_stb_o | output | 1 | One-cycle strobe for a received data byte |
| byte_data_o | output | 8 | Last received data byte |

## Verification
Each output trails its bus event by a fixed delay. The strobe and the pull-low enable both change on the third system clock edge after the relevant SCL pin transition: two synchronizer edges plus one register. The bench drives pin changes on falling clock edges and counts falling edges after the eighth data bit. It requires the strobe to be low at the second falling edge and high at the third. The acknowledge is sampled in the middle of the ninth SCL high phase, many cycles after it must already be stable. A monitor at every falling edge records each strobe, strobes longer than one cycle, and any change of the pull-low enable while the bus clock is high.

// File: rtl/i2c_wr_sink_pkg.sv
package i2c_wr_sink_pkg;

  typedef enum logic [2:0] {
    LS_IDLE = 3'd0,
    LS_ADDR = 3'd1,
    LS_ACK  = 3'd2,
    LS_DATA = 3'd3,
    LS_SKIP = 3'd4
  } link_state_t;

  // Address byte layout: [7:2] fixed, [1] select pin, [0] direction (0 = write)
  function automatic logic addr_hit(input logic [7:0] rx,
                                    input logic [5:0] fixed_hi,
                                    input logic       sel);
    return rx == {fixed_hi, sel, 1'b0};
  endfunction

endpackage

// File: rtl/i2c_wr_sync.sv
module i2c_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_q,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LINES = 2;

  logic [LINES-1:0] pin_raw;
  logic [LINES-1:0] pin_sync;
  logic             sda_s;
  logic             sda_q;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-2:0], pin_raw[g]};
    end
    assign pin_sync[g] = pipe[STAGES-1];
  end

  assign scl_s = pin_sync[0];
  assign sda_s = pin_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

endmodule

// File: rtl/i2c_wr_shift.sv
module i2c_wr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sample_en,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] next_byte,
  output logic              full
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  assign next_byte = {sreg[BYTE_W-2:0], bit_i};
  assign full      = sample_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (sample_en) begin
      sreg <= next_byte;
      cnt  <= full ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_wr_sink_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [5:0] FIXED_HI = 6'b111110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              addr_sel,
  input  logic              full,
  input  logic [BYTE_W-1:0] next_byte,
  output logic              sample_en,
  output logic              shift_clr,
  output logic              pull,
  output logic              stb,
  output logic [BYTE_W-1:0] data,
  output link_state_t       state
);

  assign sample_en = scl_rise && (state == LS_ADDR || state == LS_DATA);
  assign shift_clr = start_evt || stop_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LS_IDLE;
      pull  <= 1'b0;
      stb   <= 1'b0;
      data  <= '0;
    end else begin
      stb <= 1'b0;
      if (start_evt) begin
        state <= LS_ADDR;
        pull  <= 1'b0;
      end else if (stop_evt) begin
        state <= LS_IDLE;
        pull  <= 1'b0;
      end else begin
        unique case (state)
          LS_ADDR: if (full) begin
            state <= addr_hit(next_byte[7:0], FIXED_HI, addr_sel) ? LS_ACK : LS_SKIP;
          end
          LS_DATA: if (full) begin
            stb   <= 1'b1;
            data  <= next_byte;
            state <= LS_ACK;
          end
          LS_ACK: if (scl_fall) begin
            if (!pull) begin
              pull <= 1'b1;
            end else begin
              pull  <= 1'b0;
              state <= LS_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_wr_sink.sv
module i2c_wr_sink
  import i2c_wr_sink_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter logic [5:0] FIXED_HI    = 6'b111110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_data_o
);

  logic              scl_s, scl_q, start_evt, stop_evt, scl_rise, scl_fall;
  logic              sample_en, shift_clr, full;
  logic [BYTE_W-1:0] next_byte;
  link_state_t       fsm_state;

  i2c_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_q(scl_q), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_wr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clr(shift_clr), .sample_en(sample_en),
    .bit_i(u_sync.sda_s), .next_byte(next_byte), .full(full)
  );

  i2c_wr_fsm #(.BYTE_W(BYTE_W), .FIXED_HI(FIXED_HI)) u_fsm (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .addr_sel(addr_sel_i),
    .full(full), .next_byte(next_byte), .sample_en(sample_en),
    .shift_clr(shift_clr), .pull(sda_pull_o), .stb(byte_stb_o),
    .data(byte_data_o), .state(fsm_state)
  );

  logic unused_scl_s;
  assign unused_scl_s = scl_s;

endmodule

// File: rtl/i2c_wr_sink_chk.sv
module i2c_wr_sink_chk
  import i2c_wr_sink_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        scl_q,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        pull,
  input logic        stb,
  input link_state_t state
);

  // R8
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull) |-> !scl_q);

  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  // R4
  stb_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |-> !pull);

  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LS_SKIP) |-> (!pull && !stb));

  // R6
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (state == LS_ADDR));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (state == LS_IDLE && !pull));

endmodule

bind i2c_wr_sink i2c_wr_sink_chk u_chk (
  .clk(clk), .rst(rst), .scl_q(scl_q), .start_evt(start_evt),
  .stop_evt(stop_evt), .pull(sda_pull_o), .stb(byte_stb_o), .state(fsm_state)
);

// File: tb/i2c_wr_sink_test.sv
module i2c_wr_sink_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic stb;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  int long_stb = 0;
  int pull_viol = 0;
  logic [7:0] log_data [64];
  logic prev_stb = 1'b0;
  logic prev_pull = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_wr_sink uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_sel_i(sel),
    .sda_pull_o(sda_pull), .byte_stb_o(stb), .byte_data_o(dout)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (stb) begin
        if (stb_cnt < 64) log_data[stb_cnt] = dout;
        stb_cnt++;
        if (prev_stb) long_stb++;
      end
      if (sda_pull != prev_pull && scl_m) pull_viol++;
    end
    prev_stb  = stb;
    prev_pull = sda_pull;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(2 * Q);
      scl_m = 1'b0; wait_q(Q);
    end
  endtask

  task automatic ack_slot(output bit acked);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    acked = (sda_line == 1'b0) && sda_pull;
    wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    ack_slot(acked);
  endtask

  // sel, address byte, data byte, expected ack
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 8'hF8, 8'h5A, 1'b1},
    {1'b1, 8'hFA, 8'hA5, 1'b1},
    {1'b0, 8'hFA, 8'h11, 1'b0},
    {1'b1, 8'hF8, 8'h22, 1'b0},
    {1'b0, 8'hF9, 8'h33, 1'b0},
    {1'b0, 8'h78, 8'h44, 1'b0},
    {1'b0, 8'hF8, 8'h00, 1'b1},
    {1'b1, 8'hFA, 8'hFF, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a, d;
    int s0;
    wait_q(2);
    // R1 during reset
    check(!sda_pull && !stb && dout == 8'h00, "R1 in reset", {sda_pull, stb, dout}, 0);
    wait_q(3);
    rst = 1'b0;
    wait_q(4);
    check(!sda_pull && !stb && dout == 8'h00, "R1 after reset", {sda_pull, stb, dout}, 0);

    // Table: R2, R3, R4, R5
    for (int v = 0; v < 8; v++) begin
      sel = VEC[v][17];
      bus_start();
      s0 = stb_cnt;
      send_byte(VEC[v][16:9], a);
      check(a == VEC[v][0], VEC[v][0] ? "R2 address ack" : "R3 address nack", a, VEC[v][0]);
      send_byte(VEC[v][8:1], d);
      check(stb_cnt - s0 == int'(VEC[v][0]), "R4 strobe count", stb_cnt - s0, VEC[v][0]);
      if (VEC[v][0]) begin
        check(log_data[s0] == VEC[v][8:1], "R4 byte value", log_data[s0], VEC[v][8:1]);
        check(d, "R5 data ack", d, 1);
      end else begin
        check(!d, "R3 data ignored", d, 0);
      end
      bus_stop();
    end

    // R5: stream of four bytes
    sel = 1'b0;
    bus_start();
    send_byte(8'hF8, a);
    s0 = stb_cnt;
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'h81 + 8'(k * 17)), d);
      check(d, "R5 stream ack", d, 1);
    end
    check(stb_cnt - s0 == 4, "R5 stream count", stb_cnt - s0, 4);
    for (int k = 0; k < 4; k++)
      check(log_data[s0 + k] == 8'(8'h81 + 8'(k * 17)), "R5 stream order",
            log_data[s0 + k], 8'(8'h81 + 8'(k * 17)));
    bus_stop();

    // R9: strobe latency after the eighth data rising edge
    bus_start();
    send_byte(8'hF8, a);
    send_bits(8'hC3, 7);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!stb, "R9 strobe not early", stb, 0);
    @(negedge clk);
    check(stb && dout == 8'hC3, "R9 strobe on third edge", {stb, dout}, 9'h1C3);
    wait_q(2 * Q - 3);
    scl_m = 1'b0; wait_q(Q);
    ack_slot(d);
    check(d, "R9 ack after strobe", d, 1);

    // R6: repeated START discards a partial byte
    s0 = stb_cnt;
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'hF8, a);
    check(a, "R6 address after restart", a, 1);
    send_byte(8'h3C, d);
    check(stb_cnt - s0 == 1 && log_data[s0] == 8'h3C, "R6 single byte",
          log_data[s0], 8'h3C);
    // R6: restart to a foreign address silences the target
    bus_start();
    send_byte(8'hE8, a);
    s0 = stb_cnt;
    send_byte(8'h99, d);
    check(!a && !d && stb_cnt == s0, "R6 restart to other address", {a, d}, 0);
    bus_stop();

    // R7: clocking after STOP without START
    s0 = stb_cnt;
    scl_m = 1'b0; wait_q(Q);
    send_byte(8'hF8, a);
    send_byte(8'h55, d);
    check(!a && !d && stb_cnt == s0, "R7 idle after stop", {a, d}, 0);
    scl_m = 1'b1; wait_q(Q);
    // R3 then R7: mismatch, STOP, then a valid transfer works
    bus_start();
    send_byte(8'hF9, a);
    bus_stop();
    bus_start();
    send_byte(8'hF8, a);
    send_byte(8'h6E, d);
    check(a && d && log_data[stb_cnt - 1] == 8'h6E, "R7 recovery", log_data[stb_cnt - 1], 8'h6E);
    bus_stop();

    check(long_stb == 0, "R4 strobe width", long_stb, 0);
    check(pull_viol == 0, "R8 pull change with SCL high", pull_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule